// File: doc/BRIEF.md
# Multi-Rate Clock-Enable Generator

This block lets a single fast reference clock drive logic that works at several slower rates. Instead of building derived clocks, it produces one-cycle enable strobes. Downstream registers keep running on the reference clock and update only when their enable is high. Every related rate then shares one clock net. Throughput is set by the enable, while timing closure stays at the reference frequency.

A mode input selects between two families of rates:

- **Power-of-two family.** The reference is divided by 1, 2, 4 and 8. A 48 MHz reference gives 48, 24, 12 and 6 MHz.
- **Thirds family.** The reference is divided by 1, 1.5, 3 and 6. A 54 MHz reference gives 54, 36, 18 and 9 MHz.

The division by 1.5 is not a clean period. It is an irregular pattern that is high on two cycles out of every three.

A separate "N of M" enable is high on N of every M reference cycles, 3 of 4 by default. On an 80 MHz clock, for example, this gives 60 MHz throughput.

All enables of one family are phase-aligned and start together after reset. A change of mode restarts them.

Top module: `rate_enable_gen`

## Requirements
- R1: While `rst` is high, every bit of `rateEn` and `partEn` is 0. On the first cycle after `rst` falls, all four `rateEn` bits and `partEn` are 1, provided `modeSel` did not change on that cycle.
- R2: `rateEn[0]` (divide by 1) is 1 on every cycle except during reset and on a mode-change cycle.
- R3: With `modeSel`=0 (power-of-two family):
  - `rateEn[1]` is high for one cycle in every 2 cycles.
  - `rateEn[2]` is high for one cycle in every 4 cycles.
  - `rateEn[3]` is high for one cycle in every 8 cycles.
  - Counting cycles from k=0 at reset release, each enable is high at k=0.
- R4: With `modeSel`=1 (thirds family), `rateEn[1]` (divide by 1.5) follows the repeating pattern 1,1,0 from k=0.
- R5: With `modeSel`=1:
  - `rateEn[2]` (divide by 3) follows the repeating pattern 1,0,0 from k=0.
  - `rateEn[3]` (divide by 6) is high only at k mod 6 = 0.
- R6: Enables are phase-aligned. Whenever `rateEn[3]` is high, `rateEn[2]` and `rateEn[1]` are also high. Whenever `rateEn[2]` is high, `rateEn[1]` is also high.
- R7: `partEn` is high at k mod `PART_M` < `PART_N`. With the defaults (3 of 4) this is the repeating pattern 1,1,1,0. It behaves the same in both modes.
- R8: Mode changes behave as follows:
  - On a cycle where `modeSel` differs from its value at the previous clock edge, all enables are 0.
  - On the next cycle, the sequences restart at k=0 in the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 1 | Rate family: 0 selects divide by 1/2/4/8, 1 selects divide by 1/1.5/3/6 |
| rateEn | output | 4 | Rate enables. Bit 0 is divide by 1; bits 1..3 are the three slower rates of the selected family |
| partEn | output | 1 | N-of-M enable |

## Verification
The main function is exercised from reset release in each family. An eight-cycle window in the power-of-two family separates the /2, /4 and /8 cadences. The same window in the thirds family tells the irregular 1,1,0 pattern apart from the plain divide-by-3, and shows a divide-by-6 pulse recurring at cycle 6.

Long runs in both modes count pulses per rate. A counter off by one would change these totals.

Mode switches in both directions confirm the one quiet cycle and the fresh restart. The 3-of-4 enable is checked across both modes to show it ignores the family select.

// File: rtl/rate_enable_pkg.sv
package rate_enable_pkg;
  // Largest power-of-two divisor is 2**BIN_STAGES
  localparam int BIN_STAGES = 3;
  localparam int MAIN_W     = BIN_STAGES;
  localparam int BIN_LEN    = 1 << BIN_STAGES;
  localparam int TRI_LEN    = 6;
  localparam int NUM_RATES  = BIN_STAGES + 1;

  typedef enum logic {
    MODE_BIN = 1'b0,
    MODE_TRI = 1'b1
  } rate_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrAll;    // restart every counter, load new mode
    logic wrapMain;  // main phase counter reached its last value
    logic wrapPart;  // N-of-M counter reached its last value
    logic quiet;     // force all enables low this cycle
  } rate_strobe_t;
endpackage

// File: rtl/rate_enable_ctrl.sv
module rate_enable_ctrl
  import rate_enable_pkg::*;
#(
  parameter int PART_M = 4,
  localparam int PART_W = (PART_M > 1) ? $clog2(PART_M) : 1
) (
  input  logic              rst,
  input  logic              modeSel,
  input  rate_mode_e        modeQ,
  input  logic [MAIN_W-1:0] mainCnt,
  input  logic [PART_W-1:0] partCnt,
  output rate_strobe_t      stb
);
  logic [MAIN_W-1:0] mainLast;
  logic              modeMoved;

  always_comb begin
    mainLast  = (modeQ == MODE_TRI) ? MAIN_W'(TRI_LEN - 1) : MAIN_W'(BIN_LEN - 1);
    modeMoved = (rate_mode_e'(modeSel) != modeQ);

    stb.clrAll   = rst | modeMoved;
    stb.quiet    = rst | modeMoved;
    stb.wrapMain = (mainCnt == mainLast);
    stb.wrapPart = (32'(partCnt) == PART_M - 1);
  end
endmodule

// File: rtl/rate_enable_dp.sv
module rate_enable_dp
  import rate_enable_pkg::*;
#(
  parameter int PART_N = 3,
  parameter int PART_M = 4,
  localparam int PART_W = (PART_M > 1) ? $clog2(PART_M) : 1
) (
  input  logic                 clk,
  input  logic                 modeSel,
  input  rate_strobe_t         stb,
  output rate_mode_e           modeQ,
  output logic [MAIN_W-1:0]    mainCnt,
  output logic [PART_W-1:0]    partCnt,
  output logic [NUM_RATES-1:0] rateEn,
  output logic                 partEn
);
  logic [NUM_RATES-1:0] binEn;
  logic [NUM_RATES-1:0] triEn;

  // Phase counters
  always_ff @(posedge clk) begin
    if (stb.clrAll) begin
      mainCnt <= '0;
      partCnt <= '0;
      modeQ   <= rate_mode_e'(modeSel);
    end else begin
      mainCnt <= stb.wrapMain ? '0 : mainCnt + MAIN_W'(1);
      partCnt <= stb.wrapPart ? '0 : partCnt + PART_W'(1);
    end
  end

  // Power-of-two family: stage k is high when the low k bits are zero
  assign binEn[0] = 1'b1;
  for (genvar k = 1; k < NUM_RATES; k++) begin : g_bin
    assign binEn[k] = (mainCnt[k-1:0] == '0);
  end

  // Thirds family over a period of six phases
  always_comb begin
    triEn    = '0;
    triEn[0] = 1'b1;
    triEn[1] = !((mainCnt == MAIN_W'(2)) || (mainCnt == MAIN_W'(5)));
    triEn[2] = (mainCnt == MAIN_W'(0)) || (mainCnt == MAIN_W'(3));
    triEn[3] = (mainCnt == MAIN_W'(0));
  end

  always_comb begin
    if (stb.quiet) begin
      rateEn = '0;
      partEn = 1'b0;
    end else begin
      rateEn = (modeQ == MODE_TRI) ? triEn : binEn;
      partEn = (32'(partCnt) < PART_N);
    end
  end
endmodule

// File: rtl/rate_enable_gen.sv
module rate_enable_gen
  import rate_enable_pkg::*;
#(
  parameter int PART_N = 3,
  parameter int PART_M = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 modeSel,
  output logic [NUM_RATES-1:0] rateEn,
  output logic                 partEn
);
  localparam int PART_W = (PART_M > 1) ? $clog2(PART_M) : 1;

  rate_strobe_t      stb;
  rate_mode_e        modeQ;
  logic [MAIN_W-1:0] mainCnt;
  logic [PART_W-1:0] partCnt;

  rate_enable_ctrl #(.PART_M(PART_M)) u_ctrl (
    .rst     (rst),
    .modeSel (modeSel),
    .modeQ   (modeQ),
    .mainCnt (mainCnt),
    .partCnt (partCnt),
    .stb     (stb)
  );

  rate_enable_dp #(.PART_N(PART_N), .PART_M(PART_M)) u_dp (
    .clk     (clk),
    .modeSel (modeSel),
    .stb     (stb),
    .modeQ   (modeQ),
    .mainCnt (mainCnt),
    .partCnt (partCnt),
    .rateEn  (rateEn),
    .partEn  (partEn)
  );
endmodule

// File: rtl/rate_enable_checker.sv
module rate_enable_checker
  import rate_enable_pkg::*;
#(
  parameter int PART_N = 3,
  parameter int PART_M = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 modeSel,
  input logic [NUM_RATES-1:0] rateEn,
  input logic                 partEn
);
  // Counts consecutive low cycles of the N-of-M enable
  logic [7:0] gapCnt;

  always_ff @(posedge clk) begin
    if (rst || partEn || !rateEn[0]) gapCnt <= '0;
    else                             gapCnt <= gapCnt + 8'd1;
  end

  assert_start_all_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $stable(modeSel)) |-> ((&rateEn) && partEn));

  assert_base_rate_R2: assert property (@(posedge clk) disable iff (rst)
    $stable(modeSel) |-> rateEn[0]);

  assert_half_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    (!modeSel && rateEn[0]) |=> (!rateEn[0] || (rateEn[1] != $past(rateEn[1]))));

  assert_frac_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (modeSel && rateEn[0] && !rateEn[1]) |=> (rateEn[1] || !rateEn[0]));

  assert_align_R6: assert property (@(posedge clk) disable iff (rst)
    rateEn[3] |-> (rateEn[2] && rateEn[1] && rateEn[0]));

  assert_align_low_R6: assert property (@(posedge clk) disable iff (rst)
    rateEn[2] |-> rateEn[1]);

  assert_part_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (!partEn && rateEn[0]) |-> (32'(gapCnt) < PART_M - PART_N));

  assert_mode_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(modeSel) |-> ((rateEn == '0) && !partEn));
endmodule

bind rate_enable_gen rate_enable_checker #(.PART_N(PART_N), .PART_M(PART_M)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .modeSel (modeSel),
  .rateEn  (rateEn),
  .partEn  (partEn)
);

// File: tb/rate_enable_gen_bench.sv
module rate_enable_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeSel = 1'b0;
  logic [3:0] rateEn;
  logic       partEn;

  int testsRun = 0;
  int testsFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rate_enable_gen u_rate_enable_gen (
    .clk     (clk),
    .rst     (rst),
    .modeSel (modeSel),
    .rateEn  (rateEn),
    .partEn  (partEn)
  );

  // Row fields: {mode, restart, expected rateEn[3:0], expected partEn}.
  // Row k of each group is cycle k counted from reset release.
  localparam int NROWS = 16;
  localparam logic [6:0] VEC [NROWS] = '{
    // power-of-two family (R1, R3, R7)
    {1'b0, 1'b1, 4'b1111, 1'b1}, {1'b0, 1'b0, 4'b0001, 1'b1},
    {1'b0, 1'b0, 4'b0011, 1'b1}, {1'b0, 1'b0, 4'b0001, 1'b0},
    {1'b0, 1'b0, 4'b0111, 1'b1}, {1'b0, 1'b0, 4'b0001, 1'b1},
    {1'b0, 1'b0, 4'b0011, 1'b1}, {1'b0, 1'b0, 4'b0001, 1'b0},
    // thirds family (R1, R4, R5, R7)
    {1'b1, 1'b1, 4'b1111, 1'b1}, {1'b1, 1'b0, 4'b0011, 1'b1},
    {1'b1, 1'b0, 4'b0001, 1'b1}, {1'b1, 1'b0, 4'b0111, 1'b0},
    {1'b1, 1'b0, 4'b0011, 1'b1}, {1'b1, 1'b0, 4'b0001, 1'b1},
    {1'b1, 1'b0, 4'b1111, 1'b1}, {1'b1, 1'b0, 4'b0011, 1'b0}
  };

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic chkCount(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Hold reset across one edge, then release; returns at cycle k=0 + 1 ns
  task automatic doReset(input logic m);
    @(negedge clk);
    rst = 1'b1;
    modeSel = m;
    @(negedge clk);
    #1;
    chk("R1 reset quiet", {rateEn, partEn}, 5'b00000);
    rst = 1'b0;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    int c3;
    int c2;
    int c1;
    int c0;
    int cp;

    repeat (3) @(negedge clk);

    // Table walk
    for (int i = 0; i < NROWS; i++) begin
      if (VEC[i][5]) doReset(VEC[i][6]);
      else           step();
      chk(VEC[i][6] ? "R4 R5 R7 thirds table" : "R3 R7 power-of-two table",
          {rateEn, partEn}, VEC[i][4:0]);
    end

    // R3 R2 R7: pulse counts over 64 cycles, power-of-two family
    doReset(1'b0);
    c3 = 0; c2 = 0; c1 = 0; c0 = 0; cp = 0;
    for (int k = 0; k < 64; k++) begin
      if (k > 0) step();
      c3 += rateEn[3];
      c2 += rateEn[2];
      c1 += rateEn[1];
      c0 += rateEn[0];
      cp += partEn;
    end
    chkCount("R3 div8 count", c3, 8);
    chkCount("R3 div4 count", c2, 16);
    chkCount("R3 div2 count", c1, 32);
    chkCount("R2 div1 count", c0, 64);
    chkCount("R7 part count bin", cp, 48);

    // R4 R5 R7: pulse counts over 60 cycles, thirds family
    doReset(1'b1);
    c3 = 0; c2 = 0; c1 = 0; cp = 0;
    for (int k = 0; k < 60; k++) begin
      if (k > 0) step();
      c3 += rateEn[3];
      c2 += rateEn[2];
      c1 += rateEn[1];
      cp += partEn;
    end
    chkCount("R5 div6 count", c3, 10);
    chkCount("R5 div3 count", c2, 20);
    chkCount("R4 div1.5 count", c1, 40);
    chkCount("R7 part count tri", cp, 45);

    // R8: thirds -> power-of-two switch mid-sequence
    step();  // k=60 in thirds family
    @(negedge clk);
    modeSel = 1'b0;
    #1;
    chk("R8 quiet on switch", {rateEn, partEn}, 5'b00000);
    step();
    chk("R8 restart k0", {rateEn, partEn}, 5'b11111);
    step();
    chk("R8 restart k1", {rateEn, partEn}, 5'b00011);
    step();
    chk("R8 restart k2", {rateEn, partEn}, 5'b00111);

    // R8: power-of-two -> thirds switch
    @(negedge clk);
    modeSel = 1'b1;
    #1;
    chk("R8 quiet on switch back", {rateEn, partEn}, 5'b00000);
    step();
    chk("R8 R6 thirds k0", {rateEn, partEn}, 5'b11111);
    step();
    chk("R8 thirds k1", {rateEn, partEn}, 5'b00111);
    step();
    chk("R8 thirds k2", {rateEn, partEn}, 5'b00011);
    step();
    chk("R8 R7 thirds k3", {rateEn, partEn}, 5'b01110);

    // R1: reset asserted mid-run forces all enables low
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 mid-run reset", {rateEn, partEn}, 5'b00000);
    rst = 1'b0;
    #1;
    chk("R1 first cycle after release", {rateEn, partEn}, 5'b11111);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end
endmodule